// File: doc/BRIEF.md
# Endpoint Handshake Decision Unit

This block decides how a full- or low-speed USB device answers one transaction on one endpoint. When the packet receiver has finished a token (and, for OUT and SETUP, the data packet behind it), it raises a one-cycle end-of-packet strobe. Along with the strobe it presents:

- the token kind;
- the endpoint's configured type and its receive and transmit status;
- the "expect status stage" flag;
- the received data PID parity, the expected toggle and the byte count;
- the CRC check result.

One clock edge later the block presents its decision: send nothing, ACK, NAK or STALL, or send a data packet. It also raises an accept pulse when the received payload is to be committed to the endpoint buffer.

The event input is a valid-only stream. The block never back-pressures, so a strobe may arrive on every cycle and each one produces exactly one response cycle. The response side is also valid-only: the consumer (the packet transmitter) must take a response in the cycle it is presented, because nothing is held. SETUP handling follows its own rules, independent of the endpoint's normal receive status. A control endpoint awaiting its status stage turns non-empty OUT packets into STALL.

Top module: `usb_hs_sel`

## Requirements
- R1: A SETUP token (code 2) on an endpoint whose type is not control gives no response (code 0) and no accept. Endpoint type codes: 0 bulk, 1 control, 2 isochronous, 3 interrupt.
- R2: A SETUP token is never answered with NAK (code 2) or STALL (code 3), whatever the endpoint status.
- R3: A SETUP token on a control endpoint whose receive status is NAK or DISABLED gives no response and no accept. Status codes: 0 DISABLED, 1 STALL, 2 NAK, 3 VALID.
- R4: A SETUP token with good CRC on a control endpoint whose receive status is STALL or VALID is answered ACK (code 1) with accept high, and the data toggle is not compared.
- R5: On a control endpoint with the status-stage flag set and receive status VALID, an OUT (token code 0) with a non-zero byte count is answered STALL without accept. A zero-length OUT is handled as in R7. The flag has no effect on other endpoint types or other status values.
- R6: An isochronous endpoint never sends ACK, NAK or STALL. A good-CRC OUT with receive status VALID is accepted regardless of the PID parity, with no response. An IN (token code 1) with transmit status VALID sends data (code 4). Any other status gives no response.
- R7: On a bulk, interrupt or control endpoint, an OUT with good CRC and receive status VALID is answered ACK. Accept is high only when the data PID parity (1 = DATA1) equals the expected toggle.
- R8: On a non-isochronous endpoint, an OUT (using receive status) or an IN (using transmit status) is answered NAK for status NAK and STALL for status STALL. Status DISABLED gives no response. None of these accepts.
- R9: An IN with transmit status VALID on a non-isochronous endpoint sends data without accept. The CRC flag is ignored for IN tokens.
- R10: An OUT or SETUP whose CRC flag is low gives no response and no accept.
- R11: The response valid, code and accept appear on the clock edge that samples the strobe, for exactly one cycle per strobe. Token code 3 gives no response. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | End-of-packet strobe, one cycle per transaction |
| tok_kind | input | 2 | Token: 0 OUT, 1 IN, 2 SETUP, 3 reserved |
| ep_type | input | 2 | 0 bulk, 1 control, 2 isochronous, 3 interrupt |
| rx_stat | input | 2 | Receive status: 0 DISABLED, 1 STALL, 2 NAK, 3 VALID |
| tx_stat | input | 2 | Transmit status, same coding |
| status_stage | input | 1 | Control endpoint expects a zero-length status OUT |
| data_pid_odd | input | 1 | Received data PID is DATA1 |
| exp_toggle | input | 1 | Expected receive toggle (1 = DATA1) |
| byte_cnt | input | CNT_W | Payload byte count of the data packet |
| crc_ok | input | 1 | Data packet CRC check passed |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_code | output | 3 | 0 none, 1 ACK, 2 NAK, 3 STALL, 4 send data |
| rsp_accept | output | 1 | Commit received payload |

## Verification
The main function is driven with a vector table that holds one status field fixed while the token kind is varied. This separates the SETUP rules from the ordinary OUT rules on identical endpoint state. Paired vectors differ in a single input, such as endpoint type, the status-stage flag, byte count zero versus non-zero, PID parity or the CRC flag, so each rule's own input is shown to be decisive. Directed tests then cover the reset state, the single-cycle response, and back-to-back strobes carrying different decisions.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;
  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_e;

  typedef enum logic [1:0] {
    EP_BULK = 2'd0,
    EP_CTRL = 2'd1,
    EP_ISO  = 2'd2,
    EP_INTR = 2'd3
  } ep_e;

  typedef enum logic [1:0] {
    ST_DIS   = 2'd0,
    ST_STALL = 2'd1,
    ST_NAK   = 2'd2,
    ST_VALID = 2'd3
  } stat_e;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_DATA  = 3'd4
  } rsp_e;
endpackage

// File: rtl/usb_hs_setup_dec.sv
module usb_hs_setup_dec
  import usb_hs_pkg::*;
(
  input  logic [1:0] ep_type,
  input  logic [1:0] rx_stat,
  input  logic       crc_ok,
  output logic [2:0] rsp,
  output logic       acc
);
  logic status_takes_setup;

  // STALL and VALID both accept a SETUP; NAK emulates a receive error.
  assign status_takes_setup = (rx_stat == ST_VALID) || (rx_stat == ST_STALL);

  always_comb begin
    rsp = RSP_NONE;
    acc = 1'b0;
    if (ep_type == EP_CTRL && crc_ok && status_takes_setup) begin
      rsp = RSP_ACK;
      acc = 1'b1;
    end
  end
endmodule

// File: rtl/usb_hs_out_dec.sv
module usb_hs_out_dec
  import usb_hs_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic [1:0]       ep_type,
  input  logic [1:0]       rx_stat,
  input  logic             status_stage,
  input  logic             data_pid_odd,
  input  logic             exp_toggle,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             crc_ok,
  output logic [2:0]       rsp,
  output logic             acc
);
  logic nonempty;
  logic stage_stall;

  assign nonempty    = |byte_cnt;
  assign stage_stall = (ep_type == EP_CTRL) && status_stage && nonempty;

  always_comb begin
    rsp = RSP_NONE;
    acc = 1'b0;
    if (!crc_ok) begin
      rsp = RSP_NONE;
    end else if (ep_type == EP_ISO) begin
      // no handshake phase; toggle is a buffer selector only
      acc = (rx_stat == ST_VALID);
    end else begin
      unique case (rx_stat)
        ST_STALL: rsp = RSP_STALL;
        ST_NAK:   rsp = RSP_NAK;
        ST_VALID: begin
          if (stage_stall) begin
            rsp = RSP_STALL;
          end else begin
            rsp = RSP_ACK;
            acc = (data_pid_odd == exp_toggle);
          end
        end
        default:  rsp = RSP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/usb_hs_in_dec.sv
module usb_hs_in_dec
  import usb_hs_pkg::*;
(
  input  logic [1:0] ep_type,
  input  logic [1:0] tx_stat,
  output logic [2:0] rsp
);
  always_comb begin
    rsp = RSP_NONE;
    if (tx_stat == ST_VALID) begin
      rsp = RSP_DATA;
    end else if (ep_type != EP_ISO) begin
      if (tx_stat == ST_NAK)   rsp = RSP_NAK;
      if (tx_stat == ST_STALL) rsp = RSP_STALL;
    end
  end
endmodule

// File: rtl/usb_hs_sel.sv
module usb_hs_sel
  import usb_hs_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [1:0]       tok_kind,
  input  logic [1:0]       ep_type,
  input  logic [1:0]       rx_stat,
  input  logic [1:0]       tx_stat,
  input  logic             status_stage,
  input  logic             data_pid_odd,
  input  logic             exp_toggle,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             crc_ok,
  output logic             rsp_valid,
  output logic [2:0]       rsp_code,
  output logic             rsp_accept
);
  logic [2:0] setup_rsp, out_rsp, in_rsp, sel_rsp;
  logic       setup_acc, out_acc, sel_acc;

  usb_hs_setup_dec u_setup (
    .ep_type (ep_type),
    .rx_stat (rx_stat),
    .crc_ok  (crc_ok),
    .rsp     (setup_rsp),
    .acc     (setup_acc)
  );

  usb_hs_out_dec #(.CNT_W(CNT_W)) u_out (
    .ep_type      (ep_type),
    .rx_stat      (rx_stat),
    .status_stage (status_stage),
    .data_pid_odd (data_pid_odd),
    .exp_toggle   (exp_toggle),
    .byte_cnt     (byte_cnt),
    .crc_ok       (crc_ok),
    .rsp          (out_rsp),
    .acc          (out_acc)
  );

  usb_hs_in_dec u_in (
    .ep_type (ep_type),
    .tx_stat (tx_stat),
    .rsp     (in_rsp)
  );

  always_comb begin
    unique case (tok_kind)
      TOK_OUT:   begin sel_rsp = out_rsp;   sel_acc = out_acc;   end
      TOK_IN:    begin sel_rsp = in_rsp;    sel_acc = 1'b0;      end
      TOK_SETUP: begin sel_rsp = setup_rsp; sel_acc = setup_acc; end
      default:   begin sel_rsp = RSP_NONE;  sel_acc = 1'b0;      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= RSP_NONE;
      rsp_accept <= 1'b0;
    end else begin
      rsp_valid  <= pkt_valid;
      rsp_code   <= pkt_valid ? sel_rsp : RSP_NONE;
      rsp_accept <= pkt_valid & sel_acc;
    end
  end
endmodule

// File: rtl/usb_hs_sel_chk.sv
module usb_hs_sel_chk
  import usb_hs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_valid,
  input logic [1:0] tok_kind,
  input logic [1:0] ep_type,
  input logic       crc_ok,
  input logic       rsp_valid,
  input logic [2:0] rsp_code,
  input logic       rsp_accept
);
  AST_RSP_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> rsp_valid); // R11

  AST_RSP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(pkt_valid)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_code == RSP_NONE && !rsp_accept)); // R11

  AST_SETUP_NO_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && tok_kind == TOK_SETUP) |=>
      (rsp_code != RSP_NAK && rsp_code != RSP_STALL)); // R2

  AST_SETUP_NONCTRL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && tok_kind == TOK_SETUP && ep_type != EP_CTRL) |=>
      (rsp_code == RSP_NONE && !rsp_accept)); // R1

  AST_BAD_CRC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !crc_ok && tok_kind != TOK_IN) |=>
      (rsp_code == RSP_NONE && !rsp_accept)); // R10

  AST_ISO_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && ep_type == EP_ISO) |=>
      (rsp_code == RSP_NONE || rsp_code == RSP_DATA)); // R6

  AST_IN_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && tok_kind == TOK_IN) |=> !rsp_accept); // R9
endmodule

bind usb_hs_sel usb_hs_sel_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pkt_valid  (pkt_valid),
  .tok_kind   (tok_kind),
  .ep_type    (ep_type),
  .crc_ok     (crc_ok),
  .rsp_valid  (rsp_valid),
  .rsp_code   (rsp_code),
  .rsp_accept (rsp_accept)
);

// File: tb/tb_usb_hs_sel.sv
module tb_usb_hs_sel;
  localparam int CNT_W = 10;
  localparam int VW    = 30;
  localparam int NVEC  = 25;

  // {req[29:26], tok[25:24], type[23:22], rx[21:20], tx[19:18], stage[17],
  //  pid[16], exp[15], crc[14], cnt[13:4], code[3:1], acc[0]}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {4'd1,  2'd2, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'd8, 3'd0, 1'b0}, // R1 bulk
    {4'd1,  2'd2, 2'd2, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'd8, 3'd0, 1'b0}, // R1 iso
    {4'd3,  2'd2, 2'd1, 2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'd8, 3'd0, 1'b0}, // R3 NAK
    {4'd4,  2'd2, 2'd1, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'd8, 3'd1, 1'b1}, // R4 STALL
    {4'd4,  2'd2, 2'd1, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd8, 3'd1, 1'b1}, // R4 toggle off
    {4'd3,  2'd2, 2'd1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'd8, 3'd0, 1'b0}, // R3 disabled
    {4'd5,  2'd0, 2'd1, 2'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 10'd4, 3'd3, 1'b0}, // R5 stall
    {4'd5,  2'd0, 2'd1, 2'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 10'd0, 3'd1, 1'b1}, // R5 zero len
    {4'd5,  2'd0, 2'd0, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 10'd4, 3'd1, 1'b1}, // R5 bulk
    {4'd7,  2'd0, 2'd0, 2'd3, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd64, 3'd1, 1'b1}, // R7 match
    {4'd7,  2'd0, 2'd3, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd64, 3'd1, 1'b0}, // R7 mismatch
    {4'd8,  2'd0, 2'd0, 2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'd5, 3'd2, 1'b0}, // R8 OUT NAK
    {4'd8,  2'd0, 2'd0, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'd5, 3'd3, 1'b0}, // R8 OUT STALL
    {4'd8,  2'd0, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'd5, 3'd0, 1'b0}, // R8 OUT DIS
    {4'd8,  2'd1, 2'd3, 2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 10'd0, 3'd2, 1'b0}, // R8 IN NAK
    {4'd8,  2'd1, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd0, 3'd3, 1'b0}, // R8 IN STALL
    {4'd9,  2'd1, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0, 3'd4, 1'b0}, // R9 crc ignored
    {4'd6,  2'd0, 2'd2, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 10'd9, 3'd0, 1'b1}, // R6 iso OUT
    {4'd6,  2'd1, 2'd2, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'd0, 3'd4, 1'b0}, // R6 iso IN
    {4'd6,  2'd0, 2'd2, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd9, 3'd0, 1'b0}, // R6 iso NAK
    {4'd10, 2'd0, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 10'd9, 3'd0, 1'b0}, // R10 OUT
    {4'd10, 2'd2, 2'd1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 10'd8, 3'd0, 1'b0}, // R10 SETUP
    {4'd11, 2'd3, 2'd1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'd8, 3'd0, 1'b0}, // R11 rsvd
    {4'd8,  2'd1, 2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd0, 3'd0, 1'b0}, // R8 IN DIS
    {4'd5,  2'd0, 2'd1, 2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 10'd4, 3'd2, 1'b0}  // R5 NAK wins
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pkt_valid = 1'b0;
  logic [1:0]       tok_kind = '0, ep_type = '0, rx_stat = '0, tx_stat = '0;
  logic             status_stage = 1'b0, data_pid_odd = 1'b0, exp_toggle = 1'b0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic             crc_ok = 1'b0;
  logic             rsp_valid, rsp_accept;
  logic [2:0]       rsp_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usb_hs_sel #(.CNT_W(CNT_W)) dut (
    .clk, .rst_n, .pkt_valid, .tok_kind, .ep_type, .rx_stat, .tx_stat,
    .status_stage, .data_pid_odd, .exp_toggle, .byte_cnt, .crc_ok,
    .rsp_valid, .rsp_code, .rsp_accept
  );

  task automatic apply(input logic [VW-1:0] v);
    tok_kind     = v[25:24];
    ep_type      = v[23:22];
    rx_stat      = v[21:20];
    tx_stat      = v[19:18];
    status_stage = v[17];
    data_pid_odd = v[16];
    exp_toggle   = v[15];
    crc_ok       = v[14];
    byte_cnt     = v[13:4];
  endtask

  task automatic check(input int req, input logic vld, input logic [2:0] code,
                       input logic acc);
    n_chk++;
    if (rsp_valid !== vld || rsp_code !== code || rsp_accept !== acc) begin
      n_fail++;
      $display("FAIL R%0d: got valid=%0b code=%0d acc=%0b, expected valid=%0b code=%0d acc=%0b",
               req, rsp_valid, rsp_code, rsp_accept, vld, code, acc);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(11, 1'b0, 3'd0, 1'b0);            // R11 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(11, 1'b0, 3'd0, 1'b0);            // R11 idle, no strobe

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i]);
      pkt_valid = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0;
      check(int'(VEC[i][29:26]), 1'b1, VEC[i][3:1], VEC[i][0]);
    end

    // R11 response lasts a single cycle
    @(negedge clk);
    check(11, 1'b0, 3'd0, 1'b0);

    // R11 back-to-back strobes, R4 then R7 mismatch
    apply(VEC[3]);
    pkt_valid = 1'b1;
    @(negedge clk);
    check(4, 1'b1, 3'd1, 1'b1);
    apply(VEC[10]);
    @(negedge clk);
    check(7, 1'b1, 3'd1, 1'b0);
    pkt_valid = 1'b0;
    @(negedge clk);
    check(11, 1'b0, 3'd0, 1'b0);

    // R11 reset drops a pending response
    apply(VEC[9]);
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(11, 1'b0, 3'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11: watchdog expired, got running, expected finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule